// File: doc/BRIEF.md
# Micro-task control sequencer

This block is the controller for one hardware micro-task. It steps through a fixed program of control steps and holds one state for each step. In each state it drives one control word into an external datapath. The control word covers these fields:

- register-file read and write addresses, and the write enable
- the register-file input mux select
- the immediate ROM address
- the ALU opcode and the two operand selects
- the I/O port data select, address and write strobe
- two completion event pulses

Every field that a step does not name goes back to its zero default in that step. All outputs are decoded only from the current state, so each control word stays stable for a whole clock cycle.

The example program prepares and sends a beacon word, and it is split into two blocks. The first block loads an immediate and runs two ALU operations, writing each result back to the register file. A one-cycle wait state follows. The three comparison flags that the datapath returns settle during that wait cycle and are sampled at its closing edge. If the condition (not gt0) and gt1 and gt2 holds, the second block runs. That block loads another immediate, writes it to an I/O port and pulses the two events in turn. In every other case control returns to the start of the first block.

After reset the block waits idle until the task enable is high.

Top module: `mtask_sequencer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, the sequencer is idle and every output is 0, even if `task_en` is high.
- R2: In idle, all outputs stay 0 for as long as `task_en` is low. The first cycle after a clock edge that sees `task_en` high shows the first step of block A.
- R3: Step A0 drives `rf_in_sel`=2'b01 (immediate path) and `imm_addr`=0. All other outputs are 0.
- R4: Step A1 drives `rf_we`=1 and `rf_wr_addr`=2. All other outputs are 0.
- R5: Steps A2 to A5 follow in this order, one per cycle:
  - A2: `alu_op`=3'b000 with both operand selects 0.
  - A3: `rf_in_sel`=2'b11, `rf_we`=1, `rf_wr_addr`=1.
  - A4: `alu_op`=3'b010 with both operand selects 0.
  - A5: `rf_in_sel`=2'b11, `rf_we`=1, `rf_wr_addr`=0.

  In each of these steps every other output is 0.
- R6: Step A5 is followed by exactly one wait cycle in which all outputs are 0.
- R7: The flags are sampled at the clock edge that ends the wait cycle. If `!gt0 && gt1 && gt2`, the next cycle is step B0. Otherwise the next cycle is step A0. Flag values in any other cycle have no effect.
- R8: Step B0 drives `rf_in_sel`=2'b01 and `imm_addr`=6. Step B1 then drives `rf_we`=1 and `rf_wr_addr`=1. All other outputs are 0.
- R9: Step B2 drives `io_dsel`=2'b01, `io_we`=1, `io_addr`=4 and `rf_rd_addr`=1. All other outputs are 0.
- R10: Step B3 pulses `evt0` alone. Step B4 pulses `evt1` alone. Step A0 follows.
- R11: Outside idle, `task_en` has no effect: the program keeps running when it is low.
- R12: A synchronous `rst` returns the sequencer to idle, with all outputs 0, from any step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| task_en | input | 1 | Starts the task from idle |
| gt0 | input | 1 | Comparison flag 0 from the datapath |
| gt1 | input | 1 | Comparison flag 1 from the datapath |
| gt2 | input | 1 | Comparison flag 2 from the datapath |
| rf_rd_addr | output | 3 | Register-file read address |
| rf_wr_addr | output | 3 | Register-file write address |
| rf_we | output | 1 | Register-file write enable |
| rf_in_sel | output | 2 | Register-file input select (01 immediate, 11 ALU) |
| imm_addr | output | 4 | Immediate ROM address |
| alu_op | output | 3 | ALU opcode |
| op1_sel | output | 2 | First operand select |
| op2_sel | output | 1 | Second operand select |
| io_dsel | output | 2 | I/O port data select |
| io_we | output | 1 | I/O port write strobe |
| io_addr | output | 3 | I/O port address |
| evt0 | output | 1 | Completion event 0 pulse |
| evt1 | output | 1 | Completion event 1 pulse |

## Verification
Two things meet in the wait cycle: the datapath updating its flags, and the sequencer sampling them to choose the branch. The bench provokes this by driving one flag pattern during A5 and a different pattern during the wait cycle, in both directions. The branch must follow only the pattern present at the edge that closes the wait cycle. The bench judges this by checking whether the very next control word is the B0 word or the A0 word.

// File: rtl/mtseq_pkg.sv
`timescale 1ns/1ps
package mtseq_pkg;

    parameter int RF_AW   = 3;
    parameter int IMM_AW  = 4;
    parameter int PORT_AW = 3;
    parameter int ALU_OPW = 3;
    parameter int OP1_SW  = 2;
    parameter int INSEL_W = 2;
    parameter int DSEL_W  = 2;

    localparam int NUM_STEPS = 13;
    localparam int STEP_W    = $clog2(NUM_STEPS);

    typedef enum logic [STEP_W-1:0] {
        ST_IDLE = 4'd0,
        ST_A0   = 4'd1,
        ST_A1   = 4'd2,
        ST_A2   = 4'd3,
        ST_A3   = 4'd4,
        ST_A4   = 4'd5,
        ST_A5   = 4'd6,
        ST_WAIT = 4'd7,
        ST_B0   = 4'd8,
        ST_B1   = 4'd9,
        ST_B2   = 4'd10,
        ST_B3   = 4'd11,
        ST_B4   = 4'd12
    } step_e;

    typedef struct packed {
        logic [RF_AW-1:0]   rf_rd_addr;
        logic [RF_AW-1:0]   rf_wr_addr;
        logic               rf_we;
        logic [INSEL_W-1:0] rf_in_sel;
        logic [IMM_AW-1:0]  imm_addr;
        logic [ALU_OPW-1:0] alu_op;
        logic [OP1_SW-1:0]  op1_sel;
        logic               op2_sel;
        logic [DSEL_W-1:0]  io_dsel;
        logic               io_we;
        logic [PORT_AW-1:0] io_addr;
        logic               evt0;
        logic               evt1;
    } ctrl_t;

    localparam ctrl_t CTRL_DEFAULT = '0;

    localparam logic [INSEL_W-1:0] INSEL_IMM = INSEL_W'(2'b01);
    localparam logic [INSEL_W-1:0] INSEL_ALU = INSEL_W'(2'b11);

    // Branch predicate: block B runs only for flags 0,1,1
    function automatic logic take_block_b(input logic f0, input logic f1, input logic f2);
        return !f0 && f1 && f2;
    endfunction

    // Program-order successor of a step
    function automatic step_e step_after(input step_e s);
        case (s)
            ST_A0:   return ST_A1;
            ST_A1:   return ST_A2;
            ST_A2:   return ST_A3;
            ST_A3:   return ST_A4;
            ST_A4:   return ST_A5;
            ST_A5:   return ST_WAIT;
            ST_B0:   return ST_B1;
            ST_B1:   return ST_B2;
            ST_B2:   return ST_B3;
            ST_B3:   return ST_B4;
            default: return ST_IDLE;
        endcase
    endfunction

    // Control word of each step; unnamed fields keep their default
    function automatic ctrl_t ctrl_of(input step_e s);
        ctrl_t c;
        c = CTRL_DEFAULT;
        case (s)
            ST_A0: begin
                c.rf_in_sel = INSEL_IMM;
                c.imm_addr  = IMM_AW'(0);
            end
            ST_A1: begin
                c.rf_we      = 1'b1;
                c.rf_wr_addr = RF_AW'(2);
            end
            ST_A2: begin
                c.alu_op  = ALU_OPW'(3'b000);
                c.op1_sel = '0;
                c.op2_sel = 1'b0;
            end
            ST_A3: begin
                c.rf_in_sel  = INSEL_ALU;
                c.rf_we      = 1'b1;
                c.rf_wr_addr = RF_AW'(1);
            end
            ST_A4: begin
                c.alu_op  = ALU_OPW'(3'b010);
                c.op1_sel = '0;
                c.op2_sel = 1'b0;
            end
            ST_A5: begin
                c.rf_in_sel  = INSEL_ALU;
                c.rf_we      = 1'b1;
                c.rf_wr_addr = RF_AW'(0);
            end
            ST_B0: begin
                c.rf_in_sel = INSEL_IMM;
                c.imm_addr  = IMM_AW'(6);
            end
            ST_B1: begin
                c.rf_we      = 1'b1;
                c.rf_wr_addr = RF_AW'(1);
            end
            ST_B2: begin
                c.io_dsel    = DSEL_W'(2'b01);
                c.io_we      = 1'b1;
                c.io_addr    = PORT_AW'(4);
                c.rf_rd_addr = RF_AW'(1);
            end
            ST_B3:   c.evt0 = 1'b1;
            ST_B4:   c.evt1 = 1'b1;
            default: c = CTRL_DEFAULT;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mtseq_next.sv
`timescale 1ns/1ps
module mtseq_next
    import mtseq_pkg::*;
(
    input  step_e cur,
    input  logic  task_en,
    input  logic  gt0,
    input  logic  gt1,
    input  logic  gt2,
    output step_e nxt
);

    logic branch_b;

    assign branch_b = take_block_b(gt0, gt1, gt2);

    always_comb begin
        case (cur)
            ST_IDLE: nxt = task_en ? ST_A0 : ST_IDLE;
            ST_WAIT: nxt = branch_b ? ST_B0 : ST_A0;
            ST_B4:   nxt = ST_A0;
            default: nxt = step_after(cur);
        endcase
    end

endmodule

// File: rtl/mtseq_decode.sv
`timescale 1ns/1ps
module mtseq_decode
    import mtseq_pkg::*;
(
    input  step_e cur,
    output ctrl_t ctrl
);

    always_comb begin
        ctrl = ctrl_of(cur);
    end

endmodule

// File: rtl/mtask_sequencer.sv
`timescale 1ns/1ps
module mtask_sequencer
    import mtseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               task_en,
    input  logic               gt0,
    input  logic               gt1,
    input  logic               gt2,
    output logic [RF_AW-1:0]   rf_rd_addr,
    output logic [RF_AW-1:0]   rf_wr_addr,
    output logic               rf_we,
    output logic [INSEL_W-1:0] rf_in_sel,
    output logic [IMM_AW-1:0]  imm_addr,
    output logic [ALU_OPW-1:0] alu_op,
    output logic [OP1_SW-1:0]  op1_sel,
    output logic               op2_sel,
    output logic [DSEL_W-1:0]  io_dsel,
    output logic               io_we,
    output logic [PORT_AW-1:0] io_addr,
    output logic               evt0,
    output logic               evt1
);

    step_e step_q;
    step_e step_d;
    ctrl_t ctrl;

    mtseq_next next_i (
        .cur     (step_q),
        .task_en (task_en),
        .gt0     (gt0),
        .gt1     (gt1),
        .gt2     (gt2),
        .nxt     (step_d)
    );

    always_ff @(posedge clk) begin
        if (rst) step_q <= ST_IDLE;
        else     step_q <= step_d;
    end

    mtseq_decode decode_i (
        .cur  (step_q),
        .ctrl (ctrl)
    );

    assign rf_rd_addr = ctrl.rf_rd_addr;
    assign rf_wr_addr = ctrl.rf_wr_addr;
    assign rf_we      = ctrl.rf_we;
    assign rf_in_sel  = ctrl.rf_in_sel;
    assign imm_addr   = ctrl.imm_addr;
    assign alu_op     = ctrl.alu_op;
    assign op1_sel    = ctrl.op1_sel;
    assign op2_sel    = ctrl.op2_sel;
    assign io_dsel    = ctrl.io_dsel;
    assign io_we      = ctrl.io_we;
    assign io_addr    = ctrl.io_addr;
    assign evt0       = ctrl.evt0;
    assign evt1       = ctrl.evt1;

endmodule

// File: rtl/mtseq_checker.sv
`timescale 1ns/1ps
module mtseq_checker
    import mtseq_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  task_en,
    input logic  gt0,
    input logic  gt1,
    input logic  gt2,
    input step_e step_q,
    input logic  io_we,
    input logic  evt0,
    input logic  evt1
);

    a_r1_reset_to_idle: assert property (@(posedge clk)
        rst |=> (step_q == ST_IDLE));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (step_q == ST_IDLE && !task_en) |=> (step_q == ST_IDLE));

    a_r7_taken: assert property (@(posedge clk) disable iff (rst)
        (step_q == ST_WAIT && !gt0 && gt1 && gt2) |=> (step_q == ST_B0));

    a_r7_not_taken: assert property (@(posedge clk) disable iff (rst)
        (step_q == ST_WAIT && !(!gt0 && gt1 && gt2)) |=> (step_q == ST_A0));

    a_r9_port_then_evt: assert property (@(posedge clk) disable iff (rst)
        io_we |=> evt0);

    a_r10_evt_order: assert property (@(posedge clk) disable iff (rst)
        evt0 |=> (evt1 && !evt0));

    a_r10_evt_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(evt0 && evt1));

    a_r11_stay_busy: assert property (@(posedge clk) disable iff (rst)
        (step_q != ST_IDLE) |=> (step_q != ST_IDLE));

endmodule

bind mtask_sequencer mtseq_checker chk_i (
    .clk     (clk),
    .rst     (rst),
    .task_en (task_en),
    .gt0     (gt0),
    .gt1     (gt1),
    .gt2     (gt2),
    .step_q  (step_q),
    .io_we   (io_we),
    .evt0    (evt0),
    .evt1    (evt1)
);

// File: tb/mtask_sequencer_tb_top.sv
`timescale 1ns/1ps
module mtask_sequencer_tb_top;
    import mtseq_pkg::*;

    localparam int WW = 2*RF_AW + 1 + INSEL_W + IMM_AW + ALU_OPW + OP1_SW + 1
                      + DSEL_W + 1 + PORT_AW + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic task_en = 1'b0;
    logic gt0 = 1'b0, gt1 = 1'b0, gt2 = 1'b0;

    logic [RF_AW-1:0]   rf_rd_addr, rf_wr_addr;
    logic               rf_we;
    logic [INSEL_W-1:0] rf_in_sel;
    logic [IMM_AW-1:0]  imm_addr;
    logic [ALU_OPW-1:0] alu_op;
    logic [OP1_SW-1:0]  op1_sel;
    logic               op2_sel;
    logic [DSEL_W-1:0]  io_dsel;
    logic               io_we;
    logic [PORT_AW-1:0] io_addr;
    logic               evt0, evt1;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    mtask_sequencer dut_i (
        .clk(clk), .rst(rst), .task_en(task_en),
        .gt0(gt0), .gt1(gt1), .gt2(gt2),
        .rf_rd_addr(rf_rd_addr), .rf_wr_addr(rf_wr_addr), .rf_we(rf_we),
        .rf_in_sel(rf_in_sel), .imm_addr(imm_addr), .alu_op(alu_op),
        .op1_sel(op1_sel), .op2_sel(op2_sel), .io_dsel(io_dsel),
        .io_we(io_we), .io_addr(io_addr), .evt0(evt0), .evt1(evt1)
    );

    wire [WW-1:0] obs = {rf_rd_addr, rf_wr_addr, rf_we, rf_in_sel, imm_addr,
                         alu_op, op1_sel, op2_sel, io_dsel, io_we, io_addr,
                         evt0, evt1};

    function automatic logic [WW-1:0] mk(int rd, int wr, bit we, int insel, int imm,
                                         int op, int o1, bit o2, int ds, bit iow,
                                         int ioa, bit e0, bit e1);
        return {RF_AW'(rd), RF_AW'(wr), we, INSEL_W'(insel), IMM_AW'(imm),
                ALU_OPW'(op), OP1_SW'(o1), o2, DSEL_W'(ds), iow, PORT_AW'(ioa),
                e0, e1};
    endfunction

    localparam logic [WW-1:0] W_IDLE = '0;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string rq, logic [WW-1:0] exp);
        n_chk++;
        if (obs !== exp) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", rq, obs, exp);
        end
    endtask

    task automatic set_flags(bit f0, bit f1, bit f2);
        gt0 = f0; gt1 = f1; gt2 = f2;
    endtask

    // Walks A0..A5 and the wait cycle; optional early flag pattern during A5
    task automatic run_block_a(string first_tag, bit early, bit f0, bit f1, bit f2);
        tick(); chk(first_tag, mk(0,0,0,1,0,0,0,0,0,0,0,0,0)); // R3 word
        tick(); chk("R4", mk(0,2,1,0,0,0,0,0,0,0,0,0,0));
        tick(); chk("R5", mk(0,0,0,0,0,0,0,0,0,0,0,0,0));
        tick(); chk("R5", mk(0,1,1,3,0,0,0,0,0,0,0,0,0));
        tick(); chk("R5", mk(0,0,0,0,0,2,0,0,0,0,0,0,0));
        tick(); chk("R5", mk(0,0,1,3,0,0,0,0,0,0,0,0,0));
        if (early) set_flags(f0, f1, f2);
        tick(); chk("R6", W_IDLE);
    endtask

    task automatic run_block_b();
        tick(); chk("R8", mk(0,0,0,1,6,0,0,0,0,0,0,0,0));
        tick(); chk("R8", mk(0,1,1,0,0,0,0,0,0,0,0,0,0));
        tick(); chk("R9", mk(1,0,0,0,0,0,0,0,1,1,4,0,0));
        tick(); chk("R10", mk(0,0,0,0,0,0,0,0,0,0,0,1,0));
        tick(); chk("R10", mk(0,0,0,0,0,0,0,0,0,0,0,0,1));
    endtask

    task automatic t_reset();
        task_en = 1'b1;
        repeat (3) begin tick(); chk("R1", W_IDLE); end
        task_en = 1'b0;
        rst = 1'b0;
        tick(); chk("R1", W_IDLE);
    endtask

    task automatic t_idle_hold();
        repeat (4) begin tick(); chk("R2", W_IDLE); end
        task_en = 1'b1;
    endtask

    task automatic t_first_pass();
        run_block_a("R2", 1'b0, 1'b0, 1'b0, 1'b0);
        task_en = 1'b0;                               // R11: dropped while busy
        set_flags(1'b1, 1'b1, 1'b1);
        run_block_a("R11", 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_not_taken();
        for (int k = 0; k < 7; k++) begin
            bit [2:0] p;
            p = 3'(k);
            if (p == 3'b110) p = 3'b111;              // skip the taking pattern
            set_flags(p[0], p[1], p[2]);
            run_block_a("R7", 1'b0, 1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic t_taken();
        set_flags(1'b0, 1'b1, 1'b1);
        run_block_b();
        set_flags(1'b0, 1'b0, 1'b0);
        run_block_a("R10", 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_flag_race();
        // taking pattern during A5, replaced in the wait cycle: no branch
        set_flags(1'b0, 1'b0, 1'b0);
        run_block_a("R7", 1'b1, 1'b0, 1'b1, 1'b1);
        set_flags(1'b1, 1'b1, 1'b1);
        run_block_a("R7", 1'b1, 1'b1, 1'b0, 1'b0);
        // reverse: non-taking during A5, taking in the wait cycle
        set_flags(1'b0, 1'b1, 1'b1);
        tick(); chk("R7", mk(0,0,0,1,6,0,0,0,0,0,0,0,0));
        set_flags(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset_mid();
        tick(); chk("R8", mk(0,1,1,0,0,0,0,0,0,0,0,0,0));
        rst = 1'b1;
        tick(); chk("R12", W_IDLE);
        rst = 1'b0;
        task_en = 1'b0;
        tick(); chk("R12", W_IDLE);
        tick(); chk("R2", W_IDLE);
    endtask

    initial begin
        #(8ns * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_idle_hold();
        t_first_pass();
        t_not_taken();
        t_taken();
        t_flag_race();
        t_reset_mid();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule